// File: doc/BRIEF.md
# Segment Selector Access Verifier

This block answers four privilege questions that a protected-mode processor asks about a segment selector. It can return the access-rights word of a descriptor, return the byte-granular limit of a segment, test whether a segment may be read, or test whether it may be written. The caller supplies the selector, the current privilege level, a protected-mode flag, an operand-size flag and a query code. The block fetches the 8-byte descriptor over a simple request/response port. It reports its answer as a zero flag, plus a result value with a write enable for the two queries that load a register.

The engine moves through four states: idle, fetch, check and done. A request is accepted only while the block is idle. A null selector, or a request made outside protected mode, goes straight to the done state without a fetch. The done pulse lasts one cycle. Whether the descriptor table holds the selector is left to the fetch port, which reports this through its fail response.

Top module: `sel_access_verifier`

## Requirements
- R1: A request made while `req_prot_mode` is 0 produces, one cycle after acceptance, a done pulse with `fault_ud`=1, zero flag 0 and no write, and no fetch is issued.
- R2: A selector whose bits 15:2 are all zero completes one cycle after acceptance with zero flag 0, no write and no fetch.
- R3: A fetch fail response ends the query with zero flag 0 and no write. If valid and fail are asserted in the same cycle, fail wins.
- R4: The descriptor privilege field sits in high-dword bits 14:13 (descriptor bits 46:45), and the selector RPL sits in selector bits 1:0. The privilege test fails when DPL < CPL or DPL < RPL.
- R5: For the access-rights and limit queries, a conforming code segment (S bit 12 = 1, type bits 3:2 = 11) passes whatever the privilege levels are. Non-conforming segments must pass the R4 test.
- R6: The limit is {high bits 19:16, low bits 15:0}. When high-dword bit 23 is set, the limit is shifted left by 12 and bits 11:0 are set to 1. With `req_op32`=0 only the low 16 bits are returned, zero-extended.
- R7: The access-rights result is the high dword AND 0x00FFFF00 when `req_op32`=1, and the high dword AND 0x0000FF00 when `req_op32`=0.
- R8: For system descriptors (S=0), the limit query accepts types 1, 2, 3, 9 and 11. The access-rights query accepts those types and also 4, 5 and 12. Every other system type gives zero flag 0.
- R9: Verify-readable rejects system descriptors and code segments without the read bit (type bit 1). Readable conforming code passes without a privilege test. Readable non-conforming code and all data segments must pass R4.
- R10: Verify-writable rejects system descriptors, code (type bit 3 = 1) and data without the write bit (type bit 1). Writable data must pass R4.
- R11: `done` lasts exactly one cycle. `fetch_req` stays high with a stable `fetch_sel` until a response arrives. A request made while `busy` is high is ignored.
- R12: The present bit (high-dword bit 15) has no effect on any query.
- R13: `done_wr` is 1 only when the zero flag is 1 and the query is access-rights or limit. The two verify queries never write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a query (taken only when idle) |
| req_query | input | 2 | 0 access rights, 1 limit, 2 verify read, 3 verify write |
| req_selector | input | 16 | Selector under test |
| req_cpl | input | 2 | Current privilege level |
| req_prot_mode | input | 1 | 1 when the processor is in protected mode |
| req_op32 | input | 1 | 1 for a 32-bit result, 0 for a 16-bit result |
| fetch_req | output | 1 | Descriptor fetch request, held until answered |
| fetch_sel | output | 16 | Selector whose descriptor is requested |
| fetch_valid | input | 1 | Descriptor returned on fetch_desc |
| fetch_fail | input | 1 | Descriptor could not be fetched |
| fetch_desc | input | 64 | Descriptor; high dword in bits 63:32 |
| busy | output | 1 | Query in progress |
| done | output | 1 | One-cycle completion pulse |
| done_zf | output | 1 | Zero flag result, valid with done |
| done_wr | output | 1 | Result register write enable, valid with done |
| done_value | output | 32 | Result value, meaningful when done_wr is 1 |
| fault_ud | output | 1 | Invalid-opcode fault, valid with done |

## Verification
Two events can land on the same clock edge. The first is a fetch response that asserts valid and fail together, with a descriptor that would otherwise pass. The bench expects the fail to win: a cleared zero flag and no write. The second is a new request that arrives while a fetch is still outstanding. The bench checks that the pending fetch selector does not change and that no second fetch or done pulse follows.

// File: rtl/sav_pkg.sv
package sav_pkg;
    localparam int SEL_W      = 16;
    localparam int DWORD_W    = 32;
    localparam int DESC_W     = 2 * DWORD_W;
    localparam int PL_W       = 2;
    localparam int TYPE_W     = 4;
    localparam int GRAN_SHIFT = 12;
    localparam int LIM_LO_W   = 16;
    localparam int LIM_HI_W   = 4;
    localparam int LIM_RAW_W  = LIM_LO_W + LIM_HI_W;
    localparam int HALF_W     = DWORD_W / 2;

    // System types accepted per query, one bit per type code
    localparam logic [15:0] ACCESS_SYS_OK = 16'h1A3E;
    localparam logic [15:0] LIMIT_SYS_OK  = 16'h0A0E;

    typedef enum logic [1:0] {
        Q_ACCESS = 2'd0,
        Q_LIMIT  = 2'd1,
        Q_VREAD  = 2'd2,
        Q_VWRITE = 2'd3
    } query_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    typedef struct packed {
        state_e               st;
        query_e               qry;
        logic [SEL_W-1:0]     sel;
        logic [PL_W-1:0]      cpl;
        logic                 op32;
        logic [DESC_W-1:0]    desc;
        logic                 zf;
        logic                 wr;
        logic [DWORD_W-1:0]   val;
        logic                 ud;
    } regs_t;
endpackage

// File: rtl/sav_desc_decode.sv
module sav_desc_decode
    import sav_pkg::*;
(
    input  logic [DESC_W-1:0]  desc,
    output logic [PL_W-1:0]    dpl,
    output logic               is_seg,
    output logic [TYPE_W-1:0]  kind,
    output logic [DWORD_W-1:0] hi_word,
    output logic [DWORD_W-1:0] limit
);
    localparam int GRAN_BIT = 23;
    localparam int DPL_LSB  = 13;
    localparam int S_BIT    = 12;
    localparam int TYPE_LSB = 8;
    localparam int LHI_LSB  = 16;

    logic [DWORD_W-1:0]   lo_word;
    logic [LIM_RAW_W-1:0] raw;

    always_comb begin
        hi_word = desc[DESC_W-1:DWORD_W];
        lo_word = desc[DWORD_W-1:0];
        dpl     = hi_word[DPL_LSB +: PL_W];
        is_seg  = hi_word[S_BIT];
        kind    = hi_word[TYPE_LSB +: TYPE_W];
        raw     = {hi_word[LHI_LSB +: LIM_HI_W], lo_word[LIM_LO_W-1:0]};
        if (hi_word[GRAN_BIT])
            limit = DWORD_W'({raw, {GRAN_SHIFT{1'b1}}});
        else
            limit = DWORD_W'(raw);
    end
endmodule

// File: rtl/sav_policy.sv
module sav_policy
    import sav_pkg::*;
(
    input  query_e             query,
    input  logic               is_seg,
    input  logic [TYPE_W-1:0]  kind,
    input  logic [PL_W-1:0]    dpl,
    input  logic [PL_W-1:0]    cpl,
    input  logic [PL_W-1:0]    rpl,
    output logic               pass
);
    logic priv_ok;
    logic is_code;
    logic conforming;
    logic rw_bit;

    always_comb begin
        priv_ok    = (dpl >= cpl) && (dpl >= rpl);
        is_code    = kind[3];
        conforming = kind[2];
        rw_bit     = kind[1];
        pass       = 1'b0;
        unique case (query)
            Q_ACCESS: pass = is_seg ? ((is_code && conforming) || priv_ok)
                                    : (ACCESS_SYS_OK[kind] && priv_ok);
            Q_LIMIT:  pass = is_seg ? ((is_code && conforming) || priv_ok)
                                    : (LIMIT_SYS_OK[kind] && priv_ok);
            Q_VREAD: begin
                if (!is_seg)
                    pass = 1'b0;
                else if (is_code)
                    pass = rw_bit && (conforming || priv_ok);
                else
                    pass = priv_ok;
            end
            Q_VWRITE: pass = is_seg && !is_code && rw_bit && priv_ok;
            default:  pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/sel_access_verifier.sv
module sel_access_verifier
    import sav_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_query,
    input  logic [SEL_W-1:0]    req_selector,
    input  logic [PL_W-1:0]     req_cpl,
    input  logic                req_prot_mode,
    input  logic                req_op32,
    output logic                fetch_req,
    output logic [SEL_W-1:0]    fetch_sel,
    input  logic                fetch_valid,
    input  logic                fetch_fail,
    input  logic [DESC_W-1:0]   fetch_desc,
    output logic                busy,
    output logic                done,
    output logic                done_zf,
    output logic                done_wr,
    output logic [DWORD_W-1:0]  done_value,
    output logic                fault_ud
);
    localparam logic [DWORD_W-1:0] AR_MASK32 = 32'h00FF_FF00;
    localparam logic [DWORD_W-1:0] AR_MASK16 = 32'h0000_FF00;

    regs_t r_q, r_d;

    logic [PL_W-1:0]    d_dpl;
    logic               d_is_seg;
    logic [TYPE_W-1:0]  d_kind;
    logic [DWORD_W-1:0] d_hi;
    logic [DWORD_W-1:0] d_limit;
    logic               d_pass;
    logic [DWORD_W-1:0] result;

    sav_desc_decode u_decode (
        .desc    (r_q.desc),
        .dpl     (d_dpl),
        .is_seg  (d_is_seg),
        .kind    (d_kind),
        .hi_word (d_hi),
        .limit   (d_limit)
    );

    sav_policy u_policy (
        .query  (r_q.qry),
        .is_seg (d_is_seg),
        .kind   (d_kind),
        .dpl    (d_dpl),
        .cpl    (r_q.cpl),
        .rpl    (r_q.sel[PL_W-1:0]),
        .pass   (d_pass)
    );

    always_comb begin
        unique case (r_q.qry)
            Q_ACCESS: result = d_hi & (r_q.op32 ? AR_MASK32 : AR_MASK16);
            Q_LIMIT:  result = r_q.op32 ? d_limit : DWORD_W'(d_limit[HALF_W-1:0]);
            default:  result = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.qry  = query_e'(req_query);
                    r_d.sel  = req_selector;
                    r_d.cpl  = req_cpl;
                    r_d.op32 = req_op32;
                    r_d.zf   = 1'b0;
                    r_d.wr   = 1'b0;
                    r_d.val  = '0;
                    r_d.ud   = !req_prot_mode;
                    if (!req_prot_mode || (req_selector[SEL_W-1:PL_W] == '0))
                        r_d.st = ST_DONE;
                    else
                        r_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (fetch_fail) begin
                    r_d.st = ST_DONE;
                end else if (fetch_valid) begin
                    r_d.desc = fetch_desc;
                    r_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                r_d.zf  = d_pass;
                r_d.wr  = d_pass && (r_q.qry == Q_ACCESS || r_q.qry == Q_LIMIT);
                r_d.val = result;
                r_d.st  = ST_DONE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = (r_q.st == ST_DONE);
    assign done_zf    = done && r_q.zf;
    assign done_wr    = done && r_q.wr;
    assign done_value = r_q.val;
    assign fault_ud   = done && r_q.ud;
    assign fetch_req  = (r_q.st == ST_FETCH);
    assign fetch_sel  = r_q.sel;

    a_r1_ud_outside_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_prot_mode) |=> (fault_ud && !done_zf && !done_wr && !fetch_req));

    a_r2_null_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_prot_mode && req_selector[SEL_W-1:PL_W] == '0)
            |=> (done && !done_zf && !fetch_req));

    a_r3_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_fail) |=> (done && !done_zf && !done_wr));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_valid && !fetch_fail) |=> (fetch_req && $stable(fetch_sel)));

    a_r13_write_needs_zf: assert property (@(posedge clk) disable iff (!rst_n)
        done_wr |-> done_zf);

    a_r13_ud_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ud |-> !done_wr);
endmodule

// File: tb/test_sel_access_verifier.sv
module test_sel_access_verifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_query = '0;
    logic [15:0] req_selector = '0;
    logic [1:0]  req_cpl = '0;
    logic        req_prot_mode = 1'b1;
    logic        req_op32 = 1'b1;
    logic        fetch_req;
    logic [15:0] fetch_sel;
    logic        fetch_valid = 1'b0;
    logic        fetch_fail = 1'b0;
    logic [63:0] fetch_desc = '0;
    logic        busy, done, done_zf, done_wr, fault_ud;
    logic [31:0] done_value;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sel_access_verifier i_sel_access_verifier (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_query(req_query), .req_selector(req_selector),
        .req_cpl(req_cpl), .req_prot_mode(req_prot_mode), .req_op32(req_op32),
        .fetch_req(fetch_req), .fetch_sel(fetch_sel),
        .fetch_valid(fetch_valid), .fetch_fail(fetch_fail), .fetch_desc(fetch_desc),
        .busy(busy), .done(done), .done_zf(done_zf), .done_wr(done_wr),
        .done_value(done_value), .fault_ud(fault_ud)
    );

    typedef struct packed {
        logic [1:0]  q;
        logic [15:0] sel;
        logic [1:0]  cpl;
        logic        op32;
        logic [63:0] desc;
        logic        zf;
        logic        wr;
        logic [31:0] val;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 27;
    // query: 0 access, 1 limit, 2 verify read, 3 verify write
    localparam vec_t VEC [NV] = '{
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h0005F200_00001234, 1'b1, 1'b1, 32'h00051234, 8'd6},  // R6 byte granular
        '{2'd1, 16'h0013, 2'd3, 1'b0, 64'h0005F200_00001234, 1'b1, 1'b1, 32'h00001234, 8'd6},  // R6 16-bit cut
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h0085F200_00001234, 1'b1, 1'b1, 32'h51234FFF, 8'd6},  // R6 page granular
        '{2'd0, 16'h0013, 2'd3, 1'b1, 64'h00CFFA00_0000FFFF, 1'b1, 1'b1, 32'h00CFFA00, 8'd7},  // R7 32-bit mask
        '{2'd0, 16'h0013, 2'd3, 1'b0, 64'h00CFFA00_0000FFFF, 1'b1, 1'b1, 32'h0000FA00, 8'd7},  // R7 16-bit mask
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h00009200_00000100, 1'b0, 1'b0, 32'h0,        8'd4},  // R4 DPL<CPL, R13 no write
        '{2'd2, 16'h000A, 2'd0, 1'b1, 64'h0000B200_00000100, 1'b0, 1'b0, 32'h0,        8'd4},  // R4 DPL<RPL
        '{2'd2, 16'h001A, 2'd2, 1'b1, 64'h0000D200_00000100, 1'b1, 1'b0, 32'h0,        8'd9},  // R9 equal levels, R13
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h00009E00_0000FFFF, 1'b1, 1'b1, 32'h0000FFFF, 8'd5},  // R5 conforming limit
        '{2'd0, 16'h0013, 2'd3, 1'b1, 64'h00009E00_0000FFFF, 1'b1, 1'b1, 32'h00009E00, 8'd5},  // R5 conforming rights
        '{2'd2, 16'h0013, 2'd3, 1'b1, 64'h00009E00_0000FFFF, 1'b1, 1'b0, 32'h0,        8'd9},  // R9 readable conforming
        '{2'd2, 16'h0013, 2'd3, 1'b1, 64'h0000F800_0000FFFF, 1'b0, 1'b0, 32'h0,        8'd9},  // R9 execute only
        '{2'd2, 16'h0013, 2'd3, 1'b1, 64'h00009A00_0000FFFF, 1'b0, 1'b0, 32'h0,        8'd9},  // R9 nonconf priv fail
        '{2'd3, 16'h0013, 2'd3, 1'b1, 64'h0000F200_0000FFFF, 1'b1, 1'b0, 32'h0,        8'd10}, // R10 writable
        '{2'd3, 16'h0013, 2'd3, 1'b1, 64'h0000F000_0000FFFF, 1'b0, 1'b0, 32'h0,        8'd10}, // R10 read only
        '{2'd3, 16'h0013, 2'd3, 1'b1, 64'h0000FA00_0000FFFF, 1'b0, 1'b0, 32'h0,        8'd10}, // R10 code
        '{2'd2, 16'h0013, 2'd3, 1'b1, 64'h0000E200_00000FFF, 1'b0, 1'b0, 32'h0,        8'd9},  // R9 system rejected
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h0000E200_00000FFF, 1'b1, 1'b1, 32'h00000FFF, 8'd8},  // R8 LDT limit
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h0000EC00_00000FFF, 1'b0, 1'b0, 32'h0,        8'd8},  // R8 gate no limit
        '{2'd0, 16'h0013, 2'd3, 1'b1, 64'h0000EC00_00000FFF, 1'b1, 1'b1, 32'h0000EC00, 8'd8},  // R8 gate rights
        '{2'd0, 16'h0013, 2'd3, 1'b0, 64'h0000E500_00000FFF, 1'b1, 1'b1, 32'h0000E500, 8'd8},  // R8 task gate
        '{2'd0, 16'h0013, 2'd3, 1'b1, 64'h0000EE00_00000FFF, 1'b0, 1'b0, 32'h0,        8'd8},  // R8 type 14 rejected
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h0000EB00_00000067, 1'b1, 1'b1, 32'h00000067, 8'd8},  // R8 busy TSS
        '{2'd1, 16'h0013, 2'd3, 1'b1, 64'h00007200_00000010, 1'b1, 1'b1, 32'h00000010, 8'd12}, // R12 not present
        '{2'd3, 16'h0013, 2'd3, 1'b1, 64'h00007200_00000010, 1'b1, 1'b0, 32'h0,        8'd12}, // R12 not present
        '{2'd0, 16'h0013, 2'd3, 1'b1, 64'h0000E000_00000010, 1'b0, 1'b0, 32'h0,        8'd8},  // R8 type 0 rejected
        '{2'd0, 16'h0013, 2'd3, 1'b1, 64'h00009A00_0000FFFF, 1'b0, 1'b0, 32'h0,        8'd5}   // R5 nonconf needs priv
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_query(input logic [1:0] q, input logic [15:0] sel, input logic [1:0] cpl,
                            input logic pm, input logic op32, input logic [63:0] desc,
                            input logic fv, input logic ff,
                            output logic got, output logic zf, output logic wr,
                            output logic [31:0] val, output logic ud,
                            output logic fetched, output logic pulse_ok);
        got = 0; zf = 0; wr = 0; val = '0; ud = 0; fetched = 0; pulse_ok = 0;
        @(negedge clk);
        req_valid = 1; req_query = q; req_selector = sel; req_cpl = cpl;
        req_prot_mode = pm; req_op32 = op32;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 20 && !got; k++) begin
            if (done) begin
                got = 1; zf = done_zf; wr = done_wr; val = done_value; ud = fault_ud;
            end else if (fetch_req) begin
                fetched = 1;
                fetch_valid = fv; fetch_fail = ff; fetch_desc = desc;
                @(negedge clk);
                fetch_valid = 0; fetch_fail = 0;
            end else begin
                @(negedge clk);
            end
        end
        if (got) begin
            @(negedge clk);
            pulse_ok = !done;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic got, zf, wr, ud, fetched, pulse_ok;
        logic [31:0] val;

        repeat (3) @(negedge clk);
        // reset state
        chk(!done && !busy && !fetch_req, "R11", "reset idle", {29'b0, done, busy, fetch_req}, 32'h0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            do_query(VEC[i].q, VEC[i].sel, VEC[i].cpl, 1'b1, VEC[i].op32, VEC[i].desc,
                     1'b1, 1'b0, got, zf, wr, val, ud, fetched, pulse_ok);
            chk(got, $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d done", i), {31'b0, got}, 32'h1);
            chk(zf == VEC[i].zf, $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d zf", i), {31'b0, zf}, {31'b0, VEC[i].zf});
            chk(wr == VEC[i].wr, "R13", $sformatf("vec %0d write", i), {31'b0, wr}, {31'b0, VEC[i].wr});
            if (VEC[i].wr)
                chk(val == VEC[i].val, $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d value", i), val, VEC[i].val);
            chk(pulse_ok, "R11", $sformatf("vec %0d single pulse", i), {31'b0, pulse_ok}, 32'h1);
        end

        // R1: outside protected mode
        do_query(2'd1, 16'h0013, 2'd0, 1'b0, 1'b1, 64'h0005F200_00001234, 1'b1, 1'b0,
                 got, zf, wr, val, ud, fetched, pulse_ok);
        chk(got && ud, "R1", "ud raised", {30'b0, got, ud}, 32'h3);
        chk(!zf && !wr && !fetched, "R1", "no flag/write/fetch", {29'b0, zf, wr, fetched}, 32'h0);

        // R2: null selector with nonzero RPL
        do_query(2'd0, 16'h0003, 2'd0, 1'b1, 1'b1, 64'h0000F200_0000FFFF, 1'b1, 1'b0,
                 got, zf, wr, val, ud, fetched, pulse_ok);
        chk(got && !zf && !wr, "R2", "null clears zf", {29'b0, got, zf, wr}, 32'h4);
        chk(!fetched && !ud, "R2", "no fetch", {30'b0, fetched, ud}, 32'h0);

        // R3: fetch fail alone
        do_query(2'd1, 16'h0013, 2'd3, 1'b1, 1'b1, 64'h0005F200_00001234, 1'b0, 1'b1,
                 got, zf, wr, val, ud, fetched, pulse_ok);
        chk(got && fetched && !zf && !wr, "R3", "fail only", {28'b0, got, fetched, zf, wr}, 32'hC);

        // R3: valid and fail together, fail wins
        do_query(2'd1, 16'h0013, 2'd3, 1'b1, 1'b1, 64'h0005F200_00001234, 1'b1, 1'b1,
                 got, zf, wr, val, ud, fetched, pulse_ok);
        chk(got && fetched && !zf && !wr, "R3", "valid+fail", {28'b0, got, fetched, zf, wr}, 32'hC);

        // R11: request during an outstanding fetch is ignored
        @(negedge clk);
        req_valid = 1; req_query = 2'd2; req_selector = 16'h0013; req_cpl = 2'd3;
        req_prot_mode = 1; req_op32 = 1;
        @(negedge clk);
        req_selector = 16'h0023; req_query = 2'd3;
        chk(fetch_req && fetch_sel == 16'h0013, "R11", "first fetch", {15'b0, fetch_req, fetch_sel}, 32'h10013);
        @(negedge clk);
        req_valid = 0;
        chk(fetch_req && fetch_sel == 16'h0013, "R11", "fetch held", {15'b0, fetch_req, fetch_sel}, 32'h10013);
        fetch_valid = 1; fetch_desc = 64'h0000F000_0000FFFF;
        @(negedge clk);
        fetch_valid = 0;
        @(negedge clk);
        // read-only data: verify-read passes, verify-write would fail
        chk(done && done_zf, "R11", "first query answered", {30'b0, done, done_zf}, 32'h3);
        begin
            int extra = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (done || fetch_req) extra++;
            end
            chk(extra == 0, "R11", "no second query", extra, 32'h0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule